// File: doc/BRIEF.md
# ADC Offset Trim and Zero-Offset Self-Calibrator

This block sits on the digital result path of an analog-to-digital converter. Every raw conversion result that arrives with its valid strobe is corrected by adding a signed trim value. The sum is clamped to the converter's code range and presented one clock later. The trim lives in a small register that software can write and read back through a simple one-word register port.

A start pulse launches an automatic zero-offset calibration. The block points the converter at its internal low reference and loads a deliberate positive bias into the trim. It then averages a fixed, power-of-two number of corrected conversions. The new trim is that bias minus the average. Because of the bias, a core that reads slightly below zero still produces a positive, measurable reading. The finished trim is written as an ordinary two's complement value. The normal input is then selected again, done pulses for one cycle, and a warning flag is raised if the computed trim lies outside the window that the trim hardware can usefully cancel.

Top module: `adc_trim_cal`

## Requirements
- R1: When `raw_valid` is sampled high, `corr_valid` is high one clock later and `corr_data` equals `raw_data` plus the signed 9-bit trim that was current at that sampling edge. When `raw_valid` is low, `corr_valid` is low one clock later.
- R2: The corrected result is clamped: a sum below 0 gives 0 and a sum above 4095 gives 4095.
- R3: After reset the trim reads 0. While no calibration is running, a cycle with `reg_wr` high loads `reg_wdata` into the trim. `reg_rdata` always shows the trim as a two's complement value.
- R4: A start pulse while idle makes `cal_busy` and `ref_low_sel` high after the next edge. From that point the trim reads the bias value 80, so conversions taken during calibration are corrected by +80.
- R5: During calibration the block accumulates the corrected value of exactly 256 valid samples. The mean is the sum divided by 256, rounded down.
- R6: At the end of calibration the trim becomes 80 minus the mean, stored directly as a signed value. If the result falls outside -256..255 it is clamped to the nearer limit.
- R7: `cal_done` is high for exactly one cycle, starting one clock edge after the edge that accepts the 256th sample. In that same cycle `cal_busy` and `ref_low_sel` return low and the new trim is readable.
- R8: While `cal_busy` is high, trim writes and further start pulses have no effect. The trim keeps reading 80 and the calibration finishes after its 256 samples as normal.
- R9: `trim_range_warn` is set when calibration finishes with an unclamped computed trim above +63 or below -64. Otherwise it is cleared at that point. It is also cleared by every accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_data | input | 12 | Raw conversion result |
| raw_valid | input | 1 | Qualifies `raw_data` |
| corr_data | output | 12 | Trimmed, clamped result |
| corr_valid | output | 1 | Qualifies `corr_data` |
| ref_low_sel | output | 1 | High to route the converter input to the internal low reference |
| reg_wr | input | 1 | Trim register write strobe |
| reg_wdata | input | 9 | Trim write value, two's complement |
| reg_rdata | output | 9 | Current trim, two's complement |
| cal_start | input | 1 | Start pulse for self-calibration |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle completion pulse |
| trim_range_warn | output | 1 | Computed trim outside +63..-64 |

## Verification
The corrected result and its valid flag are due one edge after the input is sampled. The bench therefore drives each sample on a falling edge and checks it on the next falling edge. A start pulse takes effect at the next edge, so busy, the reference select and the bias readback are checked half a cycle after that edge. For calibration, the bench counts edges from the one that accepts the 256th sample. It checks that done is still low at the first falling edge and high at the second, with busy and the reference select low and the new trim readable there. One cycle later it checks that done has dropped again. The expected mean and trim come from the bench's own sum of the clamped, biased samples it fed to the block.

// File: rtl/adc_trim_pkg.sv
package adc_trim_pkg;

   // Sequencer states of the offset calibrator
   typedef enum logic [1:0] {
      CAL_IDLE  = 2'd0,
      CAL_ACCUM = 2'd1,
      CAL_APPLY = 2'd2
   } cal_state_e;

endpackage

// File: rtl/adc_trim_apply.sv
module adc_trim_apply #(
   parameter int RAW_W  = 12,
   parameter int TRIM_W = 9,
   parameter bit CLAMP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RAW_W-1:0]  raw_data,
   input  logic              raw_valid,
   input  logic [TRIM_W-1:0] trim,
   output logic [RAW_W-1:0]  adj_now,
   output logic [RAW_W-1:0]  corr_data,
   output logic              corr_valid
);

   localparam int EXT_W = RAW_W + 2;
   localparam logic signed [EXT_W-1:0] CODE_MAX = EXT_W'((1 << RAW_W) - 1);

   logic signed [EXT_W-1:0] raw_ext;
   logic signed [EXT_W-1:0] trim_ext;
   logic signed [EXT_W-1:0] sum_ext;

   initial begin
      trim_fits_chk : assert (TRIM_W < EXT_W)
         else $error("trim width must be narrower than raw width plus two");
   end

   assign raw_ext  = signed'({2'b00, raw_data});
   assign trim_ext = signed'({{(EXT_W - TRIM_W){trim[TRIM_W-1]}}, trim});
   assign sum_ext  = raw_ext + trim_ext;

   generate
      if (CLAMP) begin : g_clamp
         always_comb begin
            if (sum_ext < 0)             adj_now = '0;
            else if (sum_ext > CODE_MAX) adj_now = '1;
            else                         adj_now = sum_ext[RAW_W-1:0];
         end
      end else begin : g_wrap
         assign adj_now = sum_ext[RAW_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         corr_data  <= '0;
         corr_valid <= 1'b0;
      end else begin
         corr_valid <= raw_valid;
         if (raw_valid) corr_data <= adj_now;
      end
   end

   // R1
   zero_trim_pass_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (raw_valid && trim == '0) |=> (corr_valid && corr_data == $past(raw_data)));

   // R1
   idle_valid_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !raw_valid |=> !corr_valid);

   generate
      if (CLAMP) begin : g_clamp_chk
         // R2
         floor_clamp_chk : assert property (@(posedge clk) disable iff (!rst_n)
            (raw_valid && raw_data == '0 && trim[TRIM_W-1]) |=> (corr_data == '0));
         // R2
         ceil_clamp_chk : assert property (@(posedge clk) disable iff (!rst_n)
            (raw_valid && raw_data == '1 && !trim[TRIM_W-1]) |=> (corr_data == '1));
      end
   endgenerate

endmodule

// File: rtl/adc_mean_accum.sv
module adc_mean_accum #(
   parameter int RAW_W  = 12,
   parameter int LOG2_N = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             add_en,
   input  logic [RAW_W-1:0] sample,
   output logic             last,
   output logic [RAW_W-1:0] mean
);

   localparam int SUM_W = RAW_W + LOG2_N;

   logic [SUM_W-1:0]  sum_q;
   logic [LOG2_N-1:0] cnt_q;

   initial begin
      sample_count_chk : assert (LOG2_N >= 4)
         else $error("sample count must be a power of two of at least 16");
   end

   assign last = add_en && (cnt_q == '1);
   assign mean = sum_q[SUM_W-1:LOG2_N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
         cnt_q <= '0;
      end else if (clear) begin
         sum_q <= '0;
         cnt_q <= '0;
      end else if (add_en) begin
         sum_q <= sum_q + SUM_W'(sample);
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R5
   count_wrap_chk : assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (cnt_q == '0));

   // R5
   no_overflow_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (add_en && !clear) |=> (sum_q >= $past(sum_q)));

endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
   import adc_trim_pkg::*;
#(
   parameter int RAW_W   = 12,
   parameter int TRIM_W  = 9,
   parameter int BIAS    = 80,
   parameter int WARN_HI = 63,
   parameter int WARN_LO = -64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_start,
   input  logic              acc_last,
   input  logic [RAW_W-1:0]  mean,
   input  logic              reg_wr,
   input  logic [TRIM_W-1:0] reg_wdata,
   output logic [TRIM_W-1:0] trim,
   output logic              busy,
   output logic              ref_low,
   output logic              done,
   output logic              warn,
   output logic              acc_clear,
   output logic              acc_run
);

   localparam int FW       = RAW_W + 2;
   localparam int TRIM_MAX = (1 << (TRIM_W - 1)) - 1;
   localparam int TRIM_MIN = -(1 << (TRIM_W - 1));
   localparam logic signed [FW-1:0] BIAS_F = FW'(BIAS);
   localparam logic signed [FW-1:0] TMAX_F = FW'(TRIM_MAX);
   localparam logic signed [FW-1:0] TMIN_F = FW'(TRIM_MIN);
   localparam logic signed [FW-1:0] WHI_F  = FW'(WARN_HI);
   localparam logic signed [FW-1:0] WLO_F  = FW'(WARN_LO);
   localparam logic [TRIM_W-1:0]    BIAS_T = TRIM_W'(BIAS);

   cal_state_e st_q;
   logic signed [FW-1:0] full_trim;
   logic [TRIM_W-1:0]    trim_new;
   logic                 out_win;

   initial begin
      bias_fits_chk : assert (BIAS > 0 && BIAS <= TRIM_MAX)
         else $error("bias must be positive and fit the trim register");
      window_chk : assert (WARN_LO < 0 && WARN_HI > 0)
         else $error("warning window must straddle zero");
   end

   assign full_trim = BIAS_F - signed'({2'b00, mean});
   assign out_win   = (full_trim > WHI_F) || (full_trim < WLO_F);

   always_comb begin
      if (full_trim > TMAX_F)      trim_new = TRIM_W'(TRIM_MAX);
      else if (full_trim < TMIN_F) trim_new = TRIM_W'(TRIM_MIN);
      else                         trim_new = full_trim[TRIM_W-1:0];
   end

   assign busy      = (st_q != CAL_IDLE);
   assign ref_low   = (st_q != CAL_IDLE);
   assign acc_clear = (st_q == CAL_IDLE);
   assign acc_run   = (st_q == CAL_ACCUM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= CAL_IDLE;
         trim <= '0;
         done <= 1'b0;
         warn <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            CAL_IDLE: begin
               if (cal_start) begin
                  st_q <= CAL_ACCUM;
                  trim <= BIAS_T;
                  warn <= 1'b0;
               end else if (reg_wr) begin
                  trim <= reg_wdata;
               end
            end
            CAL_ACCUM: begin
               if (acc_last) st_q <= CAL_APPLY;
            end
            CAL_APPLY: begin
               trim <= trim_new;
               warn <= out_win;
               done <= 1'b1;
               st_q <= CAL_IDLE;
            end
            default: st_q <= CAL_IDLE;
         endcase
      end
   end

   // R4
   start_bias_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CAL_IDLE && cal_start) |=> (busy && trim == BIAS_T && !warn));

   // R8
   hold_trim_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CAL_ACCUM) |=> (trim == $past(trim)));

   // R7
   done_idle_chk : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !ref_low));

   // R7
   done_pulse_chk : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/adc_trim_cal.sv
module adc_trim_cal #(
   parameter int RAW_W   = 12,
   parameter int TRIM_W  = 9,
   parameter int LOG2_N  = 8,
   parameter int BIAS    = 80,
   parameter int WARN_HI = 63,
   parameter int WARN_LO = -64,
   parameter bit CLAMP   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RAW_W-1:0]  raw_data,
   input  logic              raw_valid,
   output logic [RAW_W-1:0]  corr_data,
   output logic              corr_valid,
   output logic              ref_low_sel,
   input  logic              reg_wr,
   input  logic [TRIM_W-1:0] reg_wdata,
   output logic [TRIM_W-1:0] reg_rdata,
   input  logic              cal_start,
   output logic              cal_busy,
   output logic              cal_done,
   output logic              trim_range_warn
);

   logic [TRIM_W-1:0] trim;
   logic [RAW_W-1:0]  adj_now;
   logic [RAW_W-1:0]  mean;
   logic              acc_last;
   logic              acc_clear;
   logic              acc_run;
   logic              add_en;

   assign add_en    = acc_run && raw_valid;
   assign reg_rdata = trim;

   adc_trim_apply #(
      .RAW_W (RAW_W),
      .TRIM_W(TRIM_W),
      .CLAMP (CLAMP)
   ) u_apply (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_data  (raw_data),
      .raw_valid (raw_valid),
      .trim      (trim),
      .adj_now   (adj_now),
      .corr_data (corr_data),
      .corr_valid(corr_valid)
   );

   adc_mean_accum #(
      .RAW_W (RAW_W),
      .LOG2_N(LOG2_N)
   ) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (acc_clear),
      .add_en(add_en),
      .sample(adj_now),
      .last  (acc_last),
      .mean  (mean)
   );

   adc_cal_seq #(
      .RAW_W  (RAW_W),
      .TRIM_W (TRIM_W),
      .BIAS   (BIAS),
      .WARN_HI(WARN_HI),
      .WARN_LO(WARN_LO)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cal_start(cal_start),
      .acc_last (acc_last),
      .mean     (mean),
      .reg_wr   (reg_wr),
      .reg_wdata(reg_wdata),
      .trim     (trim),
      .busy     (cal_busy),
      .ref_low  (ref_low_sel),
      .done     (cal_done),
      .warn     (trim_range_warn),
      .acc_clear(acc_clear),
      .acc_run  (acc_run)
   );

   // R8
   busy_write_ignored_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (cal_busy && !cal_done && reg_wr && $past(cal_busy)) |=> (cal_done || reg_rdata == $past(reg_rdata)));

   // R4
   ref_follows_busy_chk : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_busy) |-> ref_low_sel);

endmodule

// File: tb/test_adc_trim_cal.sv
module test_adc_trim_cal;

   localparam int CLK_PERIOD = 10;
   localparam int NSAMP      = 256;
   localparam int BIAS       = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] raw_data = '0;
   logic        raw_valid = 1'b0;
   logic [11:0] corr_data;
   logic        corr_valid;
   logic        ref_low_sel;
   logic        reg_wr = 1'b0;
   logic [8:0]  reg_wdata = '0;
   logic [8:0]  reg_rdata;
   logic        cal_start = 1'b0;
   logic        cal_busy;
   logic        cal_done;
   logic        trim_range_warn;

   int n_tests = 0;
   int n_fail  = 0;
   bit ended   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   adc_trim_cal i_adc_trim_cal (
      .clk            (clk),
      .rst_n          (rst_n),
      .raw_data       (raw_data),
      .raw_valid      (raw_valid),
      .corr_data      (corr_data),
      .corr_valid     (corr_valid),
      .ref_low_sel    (ref_low_sel),
      .reg_wr         (reg_wr),
      .reg_wdata      (reg_wdata),
      .reg_rdata      (reg_rdata),
      .cal_start      (cal_start),
      .cal_busy       (cal_busy),
      .cal_done       (cal_done),
      .trim_range_warn(trim_range_warn)
   );

   function automatic int clampi(int v, int lo, int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   function automatic int noise(int pat, int i);
      if (pat == 1) begin
         case (i % 4)
            0: return 3;
            1: return -3;
            2: return 1;
            default: return -1;
         endcase
      end
      if (pat == 2) return (i % 2);
      return 0;
   endfunction

   function automatic int rd_trim();
      return int'($signed(reg_rdata));
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   task automatic write_trim(int t);
      reg_wr    = 1'b1;
      reg_wdata = 9'(t);
      @(negedge clk);
      reg_wr = 1'b0;
      chk("R3 trim readback", rd_trim(), t);
   endtask

   task automatic send_check(int r, int t);
      raw_data  = 12'(r);
      raw_valid = 1'b1;
      @(negedge clk);
      chk("R1 corr_valid", int'(corr_valid), 1);
      chk("R1/R2 corr_data", int'(corr_data), clampi(r + t, 0, 4095));
   endtask

   task automatic sweep(int t);
      write_trim(t);
      for (int r = 0; r < 4096; r += 97) send_check(r, t);
      send_check(0, t);
      send_check(1, t);
      send_check(4094, t);
      send_check(4095, t);
      raw_valid = 1'b0;
      @(negedge clk);
      chk("R1 corr_valid low", int'(corr_valid), 0);
   endtask

   task automatic run_cal(int off, int pat, bit poke);
      int sum;
      int mean;
      int full;
      int raw;
      sum = 0;
      for (int i = 0; i < NSAMP; i++)
         sum += clampi(clampi(off + noise(pat, i), 0, 4095) + BIAS, 0, 4095);
      mean = sum / NSAMP;
      full = BIAS - mean;

      cal_start = 1'b1;
      @(negedge clk);
      cal_start = 1'b0;
      chk("R4 busy after start", int'(cal_busy), 1);
      chk("R4 ref_low_sel after start", int'(ref_low_sel), 1);
      chk("R4 bias trim", rd_trim(), BIAS);
      chk("R9 warn cleared at start", int'(trim_range_warn), 0);

      for (int i = 0; i < NSAMP; i++) begin
         raw       = clampi(off + noise(pat, i), 0, 4095);
         raw_data  = 12'(raw);
         raw_valid = 1'b1;
         if (poke && i == 100) begin
            reg_wr    = 1'b1;
            reg_wdata = 9'(3);
            cal_start = 1'b1;
         end
         @(negedge clk);
         reg_wr    = 1'b0;
         cal_start = 1'b0;
         if (i == 0)
            chk("R4 biased corr_data", int'(corr_data), clampi(raw + BIAS, 0, 4095));
         if (poke && i == 100)
            chk("R8 write during busy ignored", rd_trim(), BIAS);
         if (poke && i == 101) begin
            raw_valid = 1'b0;
            @(negedge clk);
            chk("R5 gap keeps busy", int'(cal_busy), 1);
         end
      end
      raw_valid = 1'b0;
      chk("R7 done not yet", int'(cal_done), 0);
      chk("R7 busy until apply", int'(cal_busy), 1);
      @(negedge clk);
      chk("R7 done pulse", int'(cal_done), 1);
      chk("R7 busy low at done", int'(cal_busy), 0);
      chk("R7 ref_low_sel low at done", int'(ref_low_sel), 0);
      chk("R6 computed trim", rd_trim(), clampi(full, -256, 255));
      chk("R9 range warning", int'(trim_range_warn), int'(full > 63 || full < -64));
      @(negedge clk);
      chk("R7 done one cycle", int'(cal_done), 0);
      send_check(200, clampi(full, -256, 255));
      raw_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3 reset trim", rd_trim(), 0);
      chk("R1 reset corr_valid", int'(corr_valid), 0);
      chk("R4 reset busy", int'(cal_busy), 0);
      chk("R4 reset ref_low_sel", int'(ref_low_sel), 0);
      chk("R7 reset done", int'(cal_done), 0);
      chk("R9 reset warn", int'(trim_range_warn), 0);

      sweep(0);
      sweep(5);
      sweep(-7);
      sweep(63);
      sweep(-64);
      sweep(255);
      sweep(-256);

      run_cal(0, 0, 1'b0);
      run_cal(10, 1, 1'b0);
      run_cal(37, 2, 1'b0);
      run_cal(150, 1, 1'b0);
      run_cal(5, 0, 1'b1);
      run_cal(4000, 1, 1'b0);
      run_cal(4090, 1, 1'b0);

      write_trim(-12);
      send_check(30, -12);
      raw_valid = 1'b0;
      @(negedge clk);

      finish_run();
   end

endmodule